// File: doc/BRIEF.md
# Dual-Protocol Parallel Slave Port

This block is the host-facing side of a peripheral that sits on an 8-bit processor bus. A pair of strap inputs chooses how the strobes are read. In one style a separate active-low read strobe and write strobe are used. In the other style a level gives the direction (high means read) and one active-low data strobe times the transfer. The same engine serves both styles. It synchronises the combined select-and-strobe condition to the local clock, stretches every access with a wait/acknowledge output, and commits each access exactly once.

Only three address lines are decoded. Addresses 0 to 3 are plain scratch registers. Address 4 holds a pointer into a larger extended register file that is not directly addressed. Address 5 reaches the extended entry under the pointer and then steps the pointer. Address 6 reaches the same entry without stepping. Address 7 is a read-only identity byte that reports the active protocol. The port drives its data outputs only while a read is in progress and gives an active-low enable for external bus buffers over that same window.

Top module: `hostport_top`

## Requirements
- R1: After reset, rdy_n is 1, dq_oe is 0, buf_en_n is 1, and addresses 0 to 4 read 00h.
- R2: mode_sel equal to 2'b01 selects the direction-plus-strobe style. Any other value selects the separate-strobe style. Address 7 reads 01h in the first case and 00h otherwise, and writes to address 7 are ignored.
- R3: An access starts only when cs0_n, cs1_n and the active strobe are all low. The first response on rdy_n comes exactly SYNC_STAGES+1 clock edges after that condition is applied. With only one select low, nothing happens and no register changes.
- R4: In the separate-strobe style, rdy_n is low for exactly STRETCH_CYC clocks, starting at the edge given in R3. After that it returns high even while the strobe is still held low, and it stays high after the strobe is released.
- R5: In the direction-plus-strobe style, rdy_n (acknowledge) goes low STRETCH_CYC clocks after the edge given in R3, with read data already valid. It stays low while the strobe is held. It returns high at the third clock edge after the strobe rises.
- R6: A write stores dq_in as sampled at the edge where the wait ends (R4) or the acknowledge falls (R5). A later read of the same location returns that value in both styles.
- R7: dq_oe is 1 and buf_en_n is 0 only while a read access is active. Both are released as soon as a select or the strobe goes high, and a write never enables the outputs.
- R8: An access to address 5 reads or writes the extended entry selected by the pointer and then increments the pointer by one. Address 6 reads or writes the same entry and leaves the pointer unchanged. The pointer is written and read at address 4, zero-extended.
- R9: The pointer wraps from EXT_DEPTH-1 to 0.
- R10: Holding the strobe low for a long time still commits only once, so an access to address 5 steps the pointer by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 2 | Protocol straps: 2'b01 direction-plus-strobe, else separate strobes |
| cs0_n | input | 1 | Chip select 0, active low |
| cs1_n | input | 1 | Chip select 1, active low |
| rd_n | input | 1 | Read strobe, or the data strobe in direction-plus-strobe style |
| wr_n | input | 1 | Write strobe, or the direction level (1 = read) |
| addr | input | 3 | Register address |
| dq_in | input | DW | Write data from the bus |
| dq_out | output | DW | Read data to the bus, zero when not driving |
| dq_oe | output | 1 | Output enable for the data bus |
| buf_en_n | output | 1 | Active-low enable for external data buffers |
| rdy_n | output | 1 | Wait (separate-strobe style) or acknowledge (other style) |

## Verification
The assertions take certain host behaviour for granted. The straps do not change during an access. Address, direction and write data stay stable from the start of an access until its wait ends or its acknowledge falls. The read and write strobes are never low together in the separate-strobe style. At least one idle clock passes after the handshake has returned to idle before the next access begins. The stimulus follows all of this: it drives every pin at the falling clock edge, holds all fields for the whole access, and leaves a fixed idle gap longer than the re-arm time before the next access. The sweeps cover every scratch register, every extended entry through the stepping port, and every strap value.

// File: rtl/hostport_pkg.sv
package hostport_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_STRETCH = 2'd1,
    ST_DONE    = 2'd2
  } hp_state_e;

  // Direct address map (three address lines)
  localparam logic [2:0] A_PTR       = 3'd4;
  localparam logic [2:0] A_XDATA_INC = 3'd5;
  localparam logic [2:0] A_XDATA     = 3'd6;
  localparam logic [2:0] A_ID        = 3'd7;

  localparam int N_SCRATCH = 4;
  localparam int SAW       = 2;

  localparam logic [1:0] MODE_DIRSTB = 2'b01;

endpackage

// File: rtl/hostport_sync.sv
module hostport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/hostport_ctl.sv
module hostport_ctl
  import hostport_pkg::*;
#(
  parameter int DW          = 8,
  parameter int STRETCH_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dirstb,
  input  logic          act_s,
  input  logic          raw_read,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] rd_val,
  output logic          busy,
  output logic          rdy_n,
  output logic          commit,
  output logic          is_read_q,
  output logic [2:0]    addr_q,
  output logic [DW-1:0] rdata_q
);

  localparam int CW = $clog2(STRETCH_CYC + 1);

  hp_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cap;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    commit  = 1'b0;
    cap     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (act_s) begin
          state_d = ST_STRETCH;
          cnt_d   = '0;
          cap     = 1'b1;
        end
      end
      ST_STRETCH: begin
        if (!act_s) begin
          state_d = ST_IDLE;
        end else if (cnt_q == CW'(STRETCH_CYC - 1)) begin
          state_d = ST_DONE;
          commit  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DONE: begin
        if (!act_s) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // Access capture, clock-enabled at access start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_read_q <= 1'b0;
      addr_q    <= '0;
      rdata_q   <= '0;
    end else if (cap) begin
      is_read_q <= raw_read;
      addr_q    <= addr;
      rdata_q   <= rd_val;
    end
  end

  assign busy  = (state_q != ST_IDLE);
  assign rdy_n = dirstb ? (state_q != ST_DONE) : (state_q != ST_STRETCH);

  // R3
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(act_s));

  // R5
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dirstb && !rdy_n && act_s) |=> !rdy_n);

  // R4
  wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dirstb && commit) |=> rdy_n);

  // R10
  commit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

endmodule

// File: rtl/hostport_regs.sv
module hostport_regs
  import hostport_pkg::*;
#(
  parameter int DW        = 8,
  parameter int EXT_DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dirstb,
  input  logic [2:0]    rd_addr,
  input  logic [2:0]    wr_addr,
  input  logic          commit,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_val
);

  localparam int XAW = $clog2(EXT_DEPTH);

  logic [DW-1:0]  scr_q [N_SCRATCH];
  logic [DW-1:0]  scr_d [N_SCRATCH];
  logic [XAW-1:0] ptr_q, ptr_d;
  logic [DW-1:0]  ext_mem [EXT_DEPTH];
  logic           ext_we;
  logic           is_scr_wr;
  logic           is_xdata;

  assign is_scr_wr = (wr_addr < 3'(N_SCRATCH));
  assign is_xdata  = (wr_addr == A_XDATA_INC) || (wr_addr == A_XDATA);

  // Next-state logic
  always_comb begin
    for (int i = 0; i < N_SCRATCH; i++) scr_d[i] = scr_q[i];
    ptr_d  = ptr_q;
    ext_we = 1'b0;
    if (wr_en && is_scr_wr) scr_d[wr_addr[SAW-1:0]] = wdata;
    if (wr_en && wr_addr == A_PTR) ptr_d = wdata[XAW-1:0];
    if (wr_en && is_xdata) ext_we = 1'b1;
    if (commit && wr_addr == A_XDATA_INC) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SCRATCH; i++) scr_q[i] <= '0;
      ptr_q <= '0;
    end else begin
      for (int i = 0; i < N_SCRATCH; i++) scr_q[i] <= scr_d[i];
      ptr_q <= ptr_d;
    end
  end

  // Extended file: no reset, written only by the host
  always_ff @(posedge clk) begin
    if (ext_we) ext_mem[ptr_q] <= wdata;
  end

  // Read mux
  always_comb begin
    rd_val = '0;
    if (rd_addr < 3'(N_SCRATCH)) begin
      rd_val = scr_q[rd_addr[SAW-1:0]];
    end else begin
      case (rd_addr)
        A_PTR:                rd_val = DW'(ptr_q);
        A_XDATA_INC, A_XDATA: rd_val = ext_mem[ptr_q];
        A_ID:                 rd_val = DW'(dirstb);
        default:              rd_val = '0;
      endcase
    end
  end

  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_addr == A_XDATA_INC) |=> (ptr_q == XAW'($past(ptr_q) + 1'b1)));

  // R9
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_addr == A_XDATA_INC && ptr_q == '1) |=> (ptr_q == '0));

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_addr == A_XDATA) |=> $stable(ptr_q));

endmodule

// File: rtl/hostport_top.sv
module hostport_top
  import hostport_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int STRETCH_CYC = 2,
  parameter int EXT_DEPTH   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic          cs0_n,
  input  logic          cs1_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          buf_en_n,
  output logic          rdy_n
);

  logic          rst_sync_n;
  logic          dirstb;
  logic          strobe_act;
  logic          raw_act;
  logic          raw_read;
  logic          act_s;
  logic          busy;
  logic          commit;
  logic          is_read_q;
  logic [2:0]    addr_q;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rd_val;

  hostport_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  assign dirstb     = (mode_sel == MODE_DIRSTB);
  assign strobe_act = dirstb ? !rd_n : (!rd_n || !wr_n);
  assign raw_act    = !cs0_n && !cs1_n && strobe_act;
  assign raw_read   = dirstb ? wr_n : !rd_n;

  hostport_sync #(.STAGES(SYNC_STAGES)) u_act_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(raw_act), .q(act_s)
  );

  hostport_ctl #(.DW(DW), .STRETCH_CYC(STRETCH_CYC)) u_ctl (
    .clk(clk), .rst_n(rst_sync_n), .dirstb(dirstb), .act_s(act_s),
    .raw_read(raw_read), .addr(addr), .rd_val(rd_val), .busy(busy),
    .rdy_n(rdy_n), .commit(commit), .is_read_q(is_read_q),
    .addr_q(addr_q), .rdata_q(rdata_q)
  );

  hostport_regs #(.DW(DW), .EXT_DEPTH(EXT_DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .dirstb(dirstb), .rd_addr(addr),
    .wr_addr(addr_q), .commit(commit), .wr_en(commit && !is_read_q),
    .wdata(dq_in), .rd_val(rd_val)
  );

  assign dq_oe    = busy && is_read_q && raw_act && raw_read;
  assign dq_out   = dq_oe ? rdata_q : '0;
  assign buf_en_n = !dq_oe;

  // R7
  oe_no_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dq_oe |-> wr_n);

endmodule

// File: tb/sim_hostport_top.sv
module sim_hostport_top;

  logic       clk;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic       cs0_n, cs1_n, rd_n, wr_n;
  logic [2:0] addr;
  logic [7:0] dq_in;
  logic [7:0] dq_out;
  logic       dq_oe, buf_en_n, rdy_n;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 0;
  bit  dstb   = 0;
  logic [7:0] exp_ext [16];
  logic [7:0] rv;

  hostport_top u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs0_n(cs0_n),
    .cs1_n(cs1_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .buf_en_n(buf_en_n), .rdy_n(rdy_n)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_sel = m;
    dstb = (m == 2'b01);
  endtask

  // One full access with cycle-exact handshake checks
  task automatic access(input bit is_rd, input logic [2:0] a, input logic [7:0] wd,
                        input int extra, output logic [7:0] rd);
    logic er;
    rd = '0;
    @(negedge clk);
    addr = a; dq_in = wd; cs0_n = 0; cs1_n = 0;
    if (dstb) begin wr_n = is_rd; rd_n = 0; end
    else if (is_rd) rd_n = 0;
    else wr_n = 0;
    for (int e = 1; e <= 6 + extra; e++) begin
      @(posedge clk); @(negedge clk);
      er = dstb ? (e >= 5 ? 1'b0 : 1'b1) : ((e == 3 || e == 4) ? 1'b0 : 1'b1);
      chk(rdy_n === er, (e <= 3) ? "R3" : (dstb ? "R5" : "R4"), rdy_n, er);
      if (e == 5) begin
        if (is_rd) begin
          rd = dq_out;
          chk(dq_oe === 1'b1 && buf_en_n === 1'b0, "R7", {dq_oe, buf_en_n}, 2'b10);
        end else begin
          chk(dq_oe === 1'b0 && buf_en_n === 1'b1, "R7", {dq_oe, buf_en_n}, 2'b01);
        end
      end
    end
    rd_n = 1; wr_n = 1; cs0_n = 1; cs1_n = 1;
    #1;
    chk(dq_oe === 1'b0 && buf_en_n === 1'b1, "R7", {dq_oe, buf_en_n}, 2'b01);
    for (int e = 1; e <= 3; e++) begin
      @(posedge clk); @(negedge clk);
      er = dstb ? (e < 3 ? 1'b0 : 1'b1) : 1'b1;
      chk(rdy_n === er, dstb ? "R5" : "R4", rdy_n, er);
    end
    @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; set_mode(2'b00);
    cs0_n = 1; cs1_n = 1; rd_n = 1; wr_n = 1; addr = 0; dq_in = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset outputs
    chk(rdy_n === 1 && dq_oe === 0 && buf_en_n === 1, "R1",
        {rdy_n, dq_oe, buf_en_n}, 3'b101);
    rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 direct registers read zero
    for (int a = 0; a <= 4; a++) begin
      access(1, 3'(a), 8'h00, 0, rv);
      chk(rv === 8'h00, "R1", rv, 0);
    end

    // R6 scratch write/read in both styles
    for (int m = 0; m < 2; m++) begin
      set_mode(m == 0 ? 2'b00 : 2'b01);
      for (int a = 0; a < 4; a++) begin
        access(0, 3'(a), 8'(8'h5A ^ (a * 37 + m * 91)), 0, rv);
      end
      for (int a = 0; a < 4; a++) begin
        access(1, 3'(a), 8'h00, 0, rv);
        chk(rv === 8'(8'h5A ^ (a * 37 + m * 91)), "R6", rv, 8'(8'h5A ^ (a * 37 + m * 91)));
      end
    end

    // R2 identity byte across every strap value, writes ignored
    for (int m = 0; m < 4; m++) begin
      set_mode(2'(m));
      access(0, 3'd7, 8'hFF, 0, rv);
      access(1, 3'd7, 8'h00, 0, rv);
      chk(rv === (m == 1 ? 8'h01 : 8'h00), "R2", rv, (m == 1) ? 1 : 0);
    end

    // R3 only one select low: no response, no write
    set_mode(2'b00);
    access(0, 3'd0, 8'h33, 0, rv);
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      addr = 0; dq_in = 8'hEE; wr_n = 0;
      cs0_n = (s == 0) ? 1'b0 : 1'b1;
      cs1_n = (s == 0) ? 1'b1 : 1'b0;
      for (int e = 0; e < 8; e++) begin
        @(posedge clk); @(negedge clk);
        chk(rdy_n === 1'b1, "R3", rdy_n, 1);
      end
      wr_n = 1; cs0_n = 1; cs1_n = 1;
      repeat (4) @(posedge clk);
    end
    access(1, 3'd0, 8'h00, 0, rv);
    chk(rv === 8'h33, "R3", rv, 8'h33);

    // R8 stepping port near the top, R9 wrap
    access(0, 3'd4, 8'd14, 0, rv);
    access(0, 3'd5, 8'hA1, 0, rv); exp_ext[14] = 8'hA1;
    access(0, 3'd5, 8'hB2, 0, rv); exp_ext[15] = 8'hB2;
    access(1, 3'd4, 8'h00, 0, rv);
    chk(rv === 8'h00, "R9", rv, 0);
    // R8 non-stepping port
    access(0, 3'd4, 8'd14, 0, rv);
    access(1, 3'd6, 8'h00, 0, rv);
    chk(rv === exp_ext[14], "R8", rv, exp_ext[14]);
    access(1, 3'd6, 8'h00, 0, rv);
    chk(rv === exp_ext[14], "R8", rv, exp_ext[14]);
    access(1, 3'd4, 8'h00, 0, rv);
    chk(rv === 8'd14, "R8", rv, 14);
    access(1, 3'd5, 8'h00, 0, rv);
    chk(rv === exp_ext[14], "R8", rv, exp_ext[14]);
    access(1, 3'd5, 8'h00, 0, rv);
    chk(rv === exp_ext[15], "R8", rv, exp_ext[15]);
    access(1, 3'd4, 8'h00, 0, rv);
    chk(rv === 8'h00, "R9", rv, 0);

    // Full sweep of the extended file in the other style
    set_mode(2'b01);
    access(0, 3'd4, 8'd0, 0, rv);
    for (int k = 0; k < 16; k++) begin
      exp_ext[k] = 8'(k * 11 + 3);
      access(0, 3'd5, exp_ext[k], 0, rv);
    end
    access(1, 3'd4, 8'h00, 0, rv);
    chk(rv === 8'h00, "R9", rv, 0);
    for (int k = 0; k < 16; k++) begin
      access(1, 3'd5, 8'h00, 0, rv);
      chk(rv === exp_ext[k], "R8", rv, exp_ext[k]);
    end

    // R10 long strobe commits once, both styles
    for (int m = 0; m < 2; m++) begin
      set_mode(m == 0 ? 2'b00 : 2'b01);
      access(0, 3'd4, 8'd3, 0, rv);
      access(0, 3'd5, 8'h7C, 10, rv);
      access(1, 3'd4, 8'h00, 0, rv);
      chk(rv === 8'd4, "R10", rv, 4);
      access(1, 3'd6, 8'h00, 0, rv);
      chk(rv === exp_ext[4], "R10", rv, exp_ext[4]);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule